// File: doc/BRIEF.md
# Asynchronous Host Register Handshake Port

This block sits between a host processor and a bank of registers clocked by the system clock. The host runs on a clock of its own, so every access is paced by a ready line rather than by a shared clock. The host has two active-low selects. One reaches the per-port and chip registers. The other reaches the system registers and the storage-access path. It also drives an 8-bit address and a write-enable line, and shares a 16-bit tri-state data bus with the block.

When a select falls, ready is pulled low with no clock involved. The first rising edge of the system clock that finds the select low is the access edge, and ready is released on that edge. On a write, the address, data and target space are captured on the access edge. One clock-wide write strobe is then raised towards the register bank. On a read, the register bank returns data for the live address. That data is snapshotted on the access edge and driven onto the host bus until the select rises, and a one-clock read strobe tells the bank that the location was read.

The register contents and the storage bus are outside this block. The bank only sees the live lookup address, the read data it returns for that address, and the registered access strobes.

Top module: `hrp_host_port`

## Requirements
- R1: When either select falls while the other stays high, `host_rdy` is driven low at once, before any rising edge of `clk`.
- R2: `host_rdy` goes high on the first rising edge of `clk` that samples a select low. It stays high for as long as that select stays low, over any number of clocks.
- R3: A write (`host_wr_n` = 0) captures `host_addr` and `host_data` on the access edge. From that edge, `acc_wr` is high for exactly one clock, with `acc_addr`/`acc_data` holding the captured values and `acc_sys` = 1 for the system select and 0 for the port select.
- R4: A read (`host_wr_n` = 1) samples `rd_data_sys` (system select) or `rd_data_port` (port select) on the access edge and drives that value on `host_data` until the select rises. From the same edge, `acc_rd` is high for one clock, with `acc_addr` and `acc_sys` set as in R3.
- R5: `req_addr` follows `host_addr` without delay. `req_sys` is 1 while only the system select is low and 0 otherwise.
- R6: Each low period of a select yields exactly one strobe, however many clocks it lasts.
- R7: With both selects low together, neither `acc_wr` nor `acc_rd` is raised and `host_data` is not driven. `host_rdy` is still paced as in R1 and R2.
- R8: The block never drives `host_data` during a write or while both selects are high.
- R9: While `rst` is high, `acc_wr` and `acc_rd` stay 0, `host_data` is not driven, and `host_rdy` is held low if a select is low.
- R10: A select held high for a single rising edge of `clk` is enough to arm the next access. The next access then behaves per R1–R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_port_n | input | 1 | Active-low select for port/chip registers |
| host_sel_sys_n | input | 1 | Active-low select for system registers and storage path |
| host_wr_n | input | 1 | Low = write, high = read |
| host_addr | input | 8 | Register address from the host |
| host_data | inout | 16 | Tri-state host data bus |
| host_rdy | output | 1 | Tri-state ready; low while an access is pending, high-impedance when unselected |
| req_addr | output | 8 | Live lookup address to the register bank |
| req_sys | output | 1 | Live space indication to the register bank |
| rd_data_port | input | 16 | Port-space read data for `req_addr` |
| rd_data_sys | input | 16 | System-space read data for `req_addr` |
| acc_wr | output | 1 | One-clock write strobe |
| acc_rd | output | 1 | One-clock read strobe |
| acc_sys | output | 1 | Space of the strobed access |
| acc_addr | output | 8 | Address of the strobed access |
| acc_data | output | 16 | Write data of the last write |

## Verification
Two events can land on the same clock edge. One is the retirement of one access's strobe. The other is the re-arming edge that prepares the next access: it sees the select high and clears the served state, and the ready-low window of the next access opens right after it. The bench provokes this by running accesses back to back, with the select high for exactly one edge between them, across a sweep of every address in both spaces and both directions. It then judges that the second access still pulls ready low before its access edge, and releases ready on that edge. It also checks that the second access raises exactly one strobe, carrying its own address, data and space.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PORT = 2'd1,
        SEL_SYS  = 2'd2,
        SEL_BOTH = 2'd3
    } sel_e;

    typedef enum logic {
        SPACE_PORT = 1'b0,
        SPACE_SYS  = 1'b1
    } space_e;

    typedef struct packed {
        logic   valid;
        logic   write;
        space_e space;
    } acc_ctl_t;

    localparam acc_ctl_t ACC_CTL_IDLE = '{valid: 1'b0, write: 1'b0, space: SPACE_PORT};

    function automatic sel_e decode_sel(input logic port_n, input logic sys_n);
        case ({sys_n, port_n})
            2'b11:   return SEL_NONE;
            2'b10:   return SEL_PORT;
            2'b01:   return SEL_SYS;
            default: return SEL_BOTH;
        endcase
    endfunction

    function automatic logic sel_single(input sel_e kind);
        return (kind == SEL_PORT) || (kind == SEL_SYS);
    endfunction

    function automatic space_e sel_space(input sel_e kind);
        return (kind == SEL_SYS) ? SPACE_SYS : SPACE_PORT;
    endfunction

endpackage

// File: rtl/hrp_sel_track.sv
module hrp_sel_track
    import hrp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_port_n,
    input  logic sel_sys_n,
    output sel_e sel_kind,
    output logic served,
    output logic legal_q,
    output logic fire,
    output logic fire_legal,
    output logic rdy_oe,
    output logic rdy_val
);

    assign sel_kind   = decode_sel(sel_port_n, sel_sys_n);
    assign fire       = (sel_kind != SEL_NONE) && !served;
    assign fire_legal = fire && sel_single(sel_kind);

    // served marks that the current select-low period has had its access edge
    always_ff @(posedge clk) begin
        if (rst) begin
            served  <= 1'b0;
            legal_q <= 1'b0;
        end else if (sel_kind == SEL_NONE) begin
            served  <= 1'b0;
            legal_q <= 1'b0;
        end else if (fire) begin
            served  <= 1'b1;
            legal_q <= fire_legal;
        end
    end

    assign rdy_oe  = (sel_kind != SEL_NONE);
    assign rdy_val = served;

endmodule

// File: rtl/hrp_access_reg.sv
module hrp_access_reg
    import hrp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_legal,
    input  logic              wr_n,
    input  sel_e              sel_kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output acc_ctl_t          ctl,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= ACC_CTL_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ctl.valid <= fire_legal;
            if (fire_legal) begin
                ctl.write <= !wr_n;
                ctl.space <= sel_space(sel_kind);
                addr_q    <= addr;
                if (!wr_n) begin
                    data_q <= din;
                end
            end
        end
    end

endmodule

// File: rtl/hrp_read_path.sv
module hrp_read_path
    import hrp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_legal,
    input  logic              wr_n,
    input  sel_e              sel_kind,
    input  logic              served,
    input  logic              legal_q,
    input  logic [DATA_W-1:0] rd_port,
    input  logic [DATA_W-1:0] rd_sys,
    output logic [DATA_W-1:0] rd_q,
    output logic              drv_en
);

    logic [DATA_W-1:0] rd_pick;

    assign rd_pick = (sel_space(sel_kind) == SPACE_SYS) ? rd_sys : rd_port;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (fire_legal && wr_n) begin
            rd_q <= rd_pick;
        end
    end

    assign drv_en = served && legal_q && wr_n && sel_single(sel_kind);

endmodule

// File: rtl/hrp_host_port.sv
module hrp_host_port
    import hrp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel_port_n,
    input  logic              host_sel_sys_n,
    input  logic              host_wr_n,
    input  logic [ADDR_W-1:0] host_addr,
    inout  wire  [DATA_W-1:0] host_data,
    output logic              host_rdy,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_sys,
    input  logic [DATA_W-1:0] rd_data_port,
    input  logic [DATA_W-1:0] rd_data_sys,
    output logic              acc_wr,
    output logic              acc_rd,
    output logic              acc_sys,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data
);

    sel_e              sel_kind;
    logic              served;
    logic              legal_q;
    logic              fire;
    logic              fire_legal;
    logic              rdy_oe;
    logic              rdy_val;
    logic              drv_en;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] host_din;
    acc_ctl_t          ctl;

    hrp_sel_track u_track (
        .clk        (clk),
        .rst        (rst),
        .sel_port_n (host_sel_port_n),
        .sel_sys_n  (host_sel_sys_n),
        .sel_kind   (sel_kind),
        .served     (served),
        .legal_q    (legal_q),
        .fire       (fire),
        .fire_legal (fire_legal),
        .rdy_oe     (rdy_oe),
        .rdy_val    (rdy_val)
    );

    hrp_access_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .fire_legal (fire_legal),
        .wr_n       (host_wr_n),
        .sel_kind   (sel_kind),
        .addr       (host_addr),
        .din        (host_din),
        .ctl        (ctl),
        .addr_q     (acc_addr),
        .data_q     (acc_data)
    );

    hrp_read_path #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk        (clk),
        .rst        (rst),
        .fire_legal (fire_legal),
        .wr_n       (host_wr_n),
        .sel_kind   (sel_kind),
        .served     (served),
        .legal_q    (legal_q),
        .rd_port    (rd_data_port),
        .rd_sys     (rd_data_sys),
        .rd_q       (rd_q),
        .drv_en     (drv_en)
    );

    assign host_din  = host_data;
    assign host_data = drv_en ? rd_q : {DATA_W{1'bz}};
    assign host_rdy  = rdy_oe ? rdy_val : 1'bz;

    assign req_addr = host_addr;
    assign req_sys  = (sel_kind == SEL_SYS);

    assign acc_wr  = ctl.valid && ctl.write;
    assign acc_rd  = ctl.valid && !ctl.write;
    assign acc_sys = (ctl.space == SPACE_SYS);

endmodule

// File: rtl/hrp_host_port_chk.sv
module hrp_host_port_chk (
    input logic clk,
    input logic rst,
    input logic sel_port_n,
    input logic sel_sys_n,
    input logic rdy_val,
    input logic served,
    input logic drv_en,
    input logic acc_wr,
    input logic acc_rd
);

    logic sel_any;
    logic sel_both;

    assign sel_any  = !(sel_port_n && sel_sys_n);
    assign sel_both = !sel_port_n && !sel_sys_n;

    assert_rdy_low_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_any && !$past(sel_any)) |-> !rdy_val);

    assert_rdy_release_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_any && !$past(sel_any)) |=> (rdy_val || !sel_any));

    assert_strobe_marks_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_wr || acc_rd) |-> $rose(served));

    assert_drive_after_ready_R4: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (rdy_val && sel_any));

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_wr || acc_rd) |=> !(acc_wr || acc_rd));

    assert_strobe_kind_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_wr, acc_rd}));

    assert_illegal_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_both && !served) |=> !(acc_wr || acc_rd));

    assert_no_drive_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !sel_any |-> !drv_en);

endmodule

bind hrp_host_port hrp_host_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_port_n (host_sel_port_n),
    .sel_sys_n  (host_sel_sys_n),
    .rdy_val    (rdy_val),
    .served     (served),
    .drv_en     (drv_en),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd)
);

// File: tb/hrp_host_port_bench.sv
module hrp_host_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_port_n = 1'b1;
    logic        sel_sys_n  = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  addr = 8'h00;
    logic        tb_oe = 1'b0;
    logic [15:0] tb_drive = 16'h0000;
    wire  [15:0] host_data;
    wire         host_rdy;
    logic [7:0]  req_addr;
    logic        req_sys;
    logic [15:0] rd_data_port;
    logic [15:0] rd_data_sys;
    logic        acc_wr, acc_rd, acc_sys;
    logic [7:0]  acc_addr;
    logic [15:0] acc_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign host_data = tb_oe ? tb_drive : 16'bz;

    // register bank model: read data is a function of the lookup address
    always_comb begin
        rd_data_port = {req_addr ^ 8'h3C, req_addr};
        rd_data_sys  = {~req_addr, req_addr ^ 8'h5A};
    end

    hrp_host_port u_hrp_host_port (
        .clk             (clk),
        .rst             (rst),
        .host_sel_port_n (sel_port_n),
        .host_sel_sys_n  (sel_sys_n),
        .host_wr_n       (wr_n),
        .host_addr       (addr),
        .host_data       (host_data),
        .host_rdy        (host_rdy),
        .req_addr        (req_addr),
        .req_sys         (req_sys),
        .rd_data_port    (rd_data_port),
        .rd_data_sys     (rd_data_sys),
        .acc_wr          (acc_wr),
        .acc_rd          (acc_rd),
        .acc_sys         (acc_sys),
        .acc_addr        (acc_addr),
        .acc_data        (acc_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input bit sys, input logic [7:0] a);
        return sys ? {~a, a ^ 8'h5A} : {a ^ 8'h3C, a};
    endfunction

    task automatic bus_idle_check(input string req);
        tb_oe = 1'b1;
        tb_drive = 16'h0000;
        #1;
        check(host_data == 16'h0000, req, {16'h0, host_data}, 32'h0);
        tb_oe = 1'b0;
    endtask

    task automatic do_access(input bit sys, input bit wr, input logic [7:0] a,
                             input logic [15:0] d, input int hold);
        @(posedge clk);
        #2;
        addr = a;
        wr_n = !wr;
        tb_oe = wr;
        tb_drive = d;
        if (sys) sel_sys_n = 1'b0; else sel_port_n = 1'b0;
        #1;
        check(host_rdy == 1'b0, "R1 ready low before edge", {31'h0, host_rdy}, 32'h0);
        check(req_addr == a && req_sys == sys, "R5 live lookup", {23'h0, req_sys, req_addr}, {23'h0, sys, a});
        @(posedge clk);
        #1;
        check(host_rdy == 1'b1, "R2 ready after edge", {31'h0, host_rdy}, 32'h1);
        if (wr) begin
            check(acc_wr && !acc_rd, "R3 write strobe", {30'h0, acc_wr, acc_rd}, 32'h2);
            check(acc_addr == a && acc_sys == sys, "R3 write addr/space", {23'h0, acc_sys, acc_addr}, {23'h0, sys, a});
            check(acc_data == d, "R3 write data", {16'h0, acc_data}, {16'h0, d});
            check(host_data == d, "R8 no drive during write", {16'h0, host_data}, {16'h0, d});
        end else begin
            check(acc_rd && !acc_wr, "R4 read strobe", {30'h0, acc_wr, acc_rd}, 32'h1);
            check(acc_addr == a && acc_sys == sys, "R4 read addr/space", {23'h0, acc_sys, acc_addr}, {23'h0, sys, a});
            check(host_data == exp_read(sys, a), "R4 read data", {16'h0, host_data}, {16'h0, exp_read(sys, a)});
        end
        for (int i = 0; i < hold; i++) begin
            @(posedge clk);
            #1;
            check(!acc_wr && !acc_rd, "R6 single strobe", {30'h0, acc_wr, acc_rd}, 32'h0);
            check(host_rdy == 1'b1, "R2 ready held", {31'h0, host_rdy}, 32'h1);
        end
        sel_port_n = 1'b1;
        sel_sys_n  = 1'b1;
        tb_oe = 1'b0;
        if (!wr && hold == 2) begin
            bus_idle_check("R8 no drive after release");
        end
    endtask

    task automatic do_illegal(input bit wr, input logic [7:0] a);
        @(posedge clk);
        #2;
        addr = a;
        wr_n = !wr;
        tb_oe = wr;
        tb_drive = 16'hA5A5;
        sel_port_n = 1'b0;
        sel_sys_n  = 1'b0;
        #1;
        check(host_rdy == 1'b0, "R7 ready low both", {31'h0, host_rdy}, 32'h0);
        @(posedge clk);
        #1;
        check(host_rdy == 1'b1, "R7 ready paced both", {31'h0, host_rdy}, 32'h1);
        check(!acc_wr && !acc_rd, "R7 no strobe", {30'h0, acc_wr, acc_rd}, 32'h0);
        if (!wr) bus_idle_check("R7 no drive both");
        @(posedge clk);
        #1;
        check(!acc_wr && !acc_rd, "R7 no strobe later", {30'h0, acc_wr, acc_rd}, 32'h0);
        sel_port_n = 1'b1;
        sel_sys_n  = 1'b1;
        tb_oe = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R9: reset with a select low
        sel_port_n = 1'b0;
        wr_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(host_rdy == 1'b0, "R9 ready held in reset", {31'h0, host_rdy}, 32'h0);
        check(!acc_wr && !acc_rd, "R9 no strobe in reset", {30'h0, acc_wr, acc_rd}, 32'h0);
        bus_idle_check("R9 no drive in reset");
        sel_port_n = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;

        // sweep: every address, both spaces, both directions, varying hold
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 256; a++) begin
                logic [15:0] d;
                d = {a[7:0], 8'hC3 ^ a[7:0]} ^ (s == 1 ? 16'h0F0F : 16'h0000);
                do_access(s[0], 1'b1, a[7:0], d, a % 3);
                do_access(s[0], 1'b0, a[7:0], 16'h0000, (a + 1) % 3);
            end
        end

        // R10: back-to-back accesses with one high edge between them
        do_access(1'b0, 1'b1, 8'h11, 16'hBEEF, 0);
        do_access(1'b1, 1'b0, 8'h22, 16'h0000, 0);
        do_access(1'b1, 1'b1, 8'h33, 16'h1357, 0);
        do_access(1'b0, 1'b0, 8'hFE, 16'h0000, 0);
        check(1'b1, "R10 back-to-back sequence", 32'h0, 32'h0);

        // R7: both selects
        do_illegal(1'b1, 8'h44);
        do_illegal(1'b0, 8'h55);
        do_access(1'b0, 1'b0, 8'h66, 16'h0000, 1);

        // R8: idle bus with no select
        @(posedge clk);
        #2;
        bus_idle_check("R8 idle no drive");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule